// File: doc/BRIEF.md
# Strap-Selected Dual-Protocol Register Slave

This block lets a host controller reach a small internal register file over one shared set of pins, using either I2C or SPI. The wire protocol is not programmed by software. Two strap levels are sampled once, on the first clock after the active-low reset is released. They choose SPI, or I2C at one of two device addresses. One of the straps shares its pin with the SPI data output. The I2C clock and data lines double as the SPI clock and data input.

Every transaction uses the same layout. A header byte carries the starting register address, and each data byte that follows uses the next address, wrapping at the end of the register file. In SPI mode, bit 7 of the header says whether the frame reads or writes. In I2C mode, the direction comes from the address byte, and the header is always written by the host before any data byte in either direction. All bus inputs pass through synchronisers into the system clock. The system clock must run at least eight times faster than the bus bit rate.

Top module: `strap_ctrl_slave`

## Requirements
- R1: The straps are captured on the first clock edge after rst_ni rises, and later strap changes have no effect. Strap A is the miso_strap_i pin and strap B is strap_b_i. A=1 selects I2C at 0xC8/0xC9. A=0 with B=0 selects I2C at 0xC2/0xC3. A=0 with B=1 selects SPI. While rst_ni is low, the bus is ignored and nothing is acknowledged.
- R2: In I2C mode, only the selected write address (LSB 0) and read address (LSB 1) are acknowledged. Any other address byte gets no acknowledge, and the rest of the transaction is ignored.
- R3: An I2C start (SDA falling while SCL is high) begins a new address byte, including a repeated start in the middle of a transaction. A stop (SDA rising while SCL is high) returns the slave to idle. Bits are taken MSB first on SCL rising edges.
- R4: On the 9th clock after an accepted address byte, header byte or write data byte, the slave pulls SDA low.
- R5: The header byte's low log2(REG_DEPTH) bits set the register address. Each data byte goes to the next address, modulo REG_DEPTH.
- R6: In an I2C read (address 0xC3 or 0xC9, then the header), the slave sends the register bytes MSB first, starting at the header address. Each acknowledge from the host moves on to the next address.
- R7: If the host leaves SDA high on the 9th clock after a read byte, the slave releases SDA and goes idle. Further clocks read as 1 until the next start.
- R8: In SPI mode 3 with chip select low, a header with bit 7 = 0 writes the data bytes that follow, MSB first on rising clock edges.
- R9: In SPI mode, a header with bit 7 = 1 returns the register data MSB first on miso_o, changing after falling edges, with auto-increment. miso_oe_o is high only in the data phase of a read frame while chip select is low.
- R10: In SPI mode, I2C traffic is not acknowledged and sda_oe_o stays low. In I2C mode, SPI frames neither write registers nor raise miso_oe_o.
- R11: SDA is open-drain: sda_oe_o=1 means pull low, and SDA is never driven high. Both output enables are low during reset. Registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset; its release latches the straps |
| scl_sclk_i | input | 1 | I2C SCL or SPI clock (shared pin) |
| sda_mosi_i | input | 1 | I2C SDA line level or SPI data in (shared pin) |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| cs_ni | input | 1 | SPI chip select, active low |
| miso_strap_i | input | 1 | Level of the shared SPI-out / strap A pin |
| strap_b_i | input | 1 | Strap B level |
| miso_o | output | 1 | SPI data out |
| miso_oe_o | output | 1 | Output enable for miso_o |

## Verification
The bench builds the block with REG_DEPTH=16 and SYNC_STAGES=2. The small register file lets bursts of four bytes or fewer cross the top address and wrap to zero, for writes and reads in both protocols. Three resets walk through all strap combinations. A bus half-bit of ten system clocks stays inside the oversampling margin. This lets every acknowledge slot and every SPI output bit be sampled a fixed distance from its edge.

// File: rtl/strap_slave_pkg.sv
package strap_slave_pkg;
  typedef enum logic [1:0] {
    MODE_I2C_LO = 2'd0,
    MODE_I2C_HI = 2'd1,
    MODE_SPI    = 2'd2
  } bus_mode_e;

  localparam logic [6:0] I2C_DEV_LO = 7'h61;  // 0xC2 / 0xC3
  localparam logic [6:0] I2C_DEV_HI = 7'h64;  // 0xC8 / 0xC9

  function automatic bus_mode_e decode_strap(logic a, logic b);
    if (a)      return MODE_I2C_HI;
    else if (b) return MODE_SPI;
    else        return MODE_I2C_LO;
  endfunction
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;  // bus lines idle high
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/slave_regs.sv
module slave_regs #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [$clog2(DEPTH)-1:0] wr_addr_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic [$clog2(DEPTH)-1:0] rd_addr_i,
  output logic [DATA_W-1:0]        rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  p_write_lands_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem_q[$past(wr_addr_i)] == $past(wr_data_i));
endmodule

// File: rtl/i2c_target.sv
module i2c_target #(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [6:0]    dev_addr_i,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i
);
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} st_e;
  typedef enum logic [1:0] {K_ADDR, K_HDR, K_DATA} kind_e;

  st_e          state_q;
  kind_e        kind_q;
  logic         scl_q, sda_q;
  logic [3:0]   cnt_q;
  logic [7:0]   rx_q, tx_q;
  logic [AW-1:0] addr_q;
  logic         is_rd_q, to_tx_q, mack_q;

  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;
  assign start_c  = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_c   = scl_i & scl_q & ~sda_q & sda_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      kind_q    <= K_ADDR;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      cnt_q     <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      addr_q    <= '0;
      is_rd_q   <= 1'b0;
      to_tx_q   <= 1'b0;
      mack_q    <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      scl_q   <= scl_i;
      sda_q   <= sda_i;
      wr_en_o <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
      end else if (start_c) begin
        state_q <= ST_RX;
        kind_q  <= K_ADDR;
        cnt_q   <= '0;
      end else if (stop_c) begin
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_RX: begin
            if (scl_rise) begin
              rx_q  <= {rx_q[6:0], sda_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall && cnt_q == 4'd8) begin
              cnt_q <= '0;
              unique case (kind_q)
                K_ADDR: begin
                  if (rx_q[7:1] == dev_addr_i) begin
                    is_rd_q <= rx_q[0];
                    to_tx_q <= 1'b0;
                    kind_q  <= K_HDR;
                    state_q <= ST_ACK;
                  end else begin
                    state_q <= ST_IDLE;
                  end
                end
                K_HDR: begin
                  addr_q  <= rx_q[AW-1:0];
                  to_tx_q <= is_rd_q;
                  kind_q  <= K_DATA;
                  state_q <= ST_ACK;
                end
                default: begin
                  wr_en_o   <= 1'b1;
                  wr_addr_o <= addr_q;
                  wr_data_o <= rx_q;
                  addr_q    <= addr_q + 1'b1;
                  state_q   <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (to_tx_q) begin
                tx_q    <= rd_data_i;
                addr_q  <= addr_q + 1'b1;
                state_q <= ST_TX;
              end else begin
                state_q <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall) begin
              if (cnt_q == 4'd8) begin
                cnt_q   <= '0;
                mack_q  <= 1'b0;
                state_q <= ST_MACK;
              end else begin
                tx_q <= {tx_q[6:0], 1'b0};
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              if (sda_i) state_q <= ST_IDLE;  // host nack acts as stop
              else       mack_q  <= 1'b1;
            end else if (scl_fall && mack_q) begin
              tx_q    <= rd_data_i;
              addr_q  <= addr_q + 1'b1;
              cnt_q   <= '0;
              state_q <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_addr_o = addr_q;
  assign sda_oe_o  = (state_q == ST_ACK) | ((state_q == ST_TX) & ~tx_q[7]);

  p_pull_after_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall));
  p_stop_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && stop_c) |=> !sda_oe_o);
  p_disabled_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sda_oe_o && !wr_en_o);
endmodule

// File: rtl/spi_target.sv
module spi_target #(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          sclk_i,
  input  logic          cs_ni,
  input  logic          mosi_i,
  output logic          miso_o,
  output logic          miso_oe_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i
);
  logic          sclk_q;
  logic [2:0]    cnt_q;
  logic [7:0]    rx_q, tx_q;
  logic [AW-1:0] addr_q;
  logic          hdr_done_q, rd_mode_q;

  logic       sclk_rise, sclk_fall, byte_end, hdr_end;
  logic [7:0] rx_next;
  assign sclk_rise = sclk_i & ~sclk_q;
  assign sclk_fall = ~sclk_i & sclk_q;
  assign rx_next   = {rx_q[6:0], mosi_i};
  assign byte_end  = en_i & ~cs_ni & sclk_rise & (cnt_q == 3'd7);
  assign hdr_end   = byte_end & ~hdr_done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q     <= 1'b1;
      cnt_q      <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      addr_q     <= '0;
      hdr_done_q <= 1'b0;
      rd_mode_q  <= 1'b0;
      wr_en_o    <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      sclk_q  <= sclk_i;
      wr_en_o <= 1'b0;
      if (!en_i || cs_ni) begin
        cnt_q      <= '0;
        hdr_done_q <= 1'b0;
        rd_mode_q  <= 1'b0;
      end else if (sclk_rise) begin
        rx_q  <= rx_next;
        cnt_q <= cnt_q + 3'd1;
        if (hdr_end) begin
          hdr_done_q <= 1'b1;
          rd_mode_q  <= rx_next[7];
          if (rx_next[7]) begin
            tx_q   <= rd_data_i;
            addr_q <= rx_next[AW-1:0] + 1'b1;
          end else begin
            addr_q <= rx_next[AW-1:0];
          end
        end else if (byte_end) begin
          addr_q <= addr_q + 1'b1;
          if (rd_mode_q) begin
            tx_q <= rd_data_i;
          end else begin
            wr_en_o   <= 1'b1;
            wr_addr_o <= addr_q;
            wr_data_o <= rx_next;
          end
        end
      end else if (sclk_fall && cnt_q != 3'd0) begin
        tx_q <= {tx_q[6:0], 1'b0};
      end
    end
  end

  assign rd_addr_o = hdr_end ? rx_next[AW-1:0] : addr_q;
  assign miso_o    = tx_q[7];
  assign miso_oe_o = rd_mode_q & hdr_done_q;

  p_miso_released_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || !en_i) |=> !miso_oe_o);
  p_single_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);
  p_no_write_in_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miso_oe_o |-> !wr_en_o);
endmodule

// File: rtl/strap_ctrl_slave.sv
module strap_ctrl_slave
  import strap_slave_pkg::*;
#(
  parameter int REG_DEPTH   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_sclk_i,
  input  logic sda_mosi_i,
  output logic sda_oe_o,
  input  logic cs_ni,
  input  logic miso_strap_i,
  input  logic strap_b_i,
  output logic miso_o,
  output logic miso_oe_o
);
  localparam int AW = $clog2(REG_DEPTH);

  bus_mode_e mode_q;
  logic      captured_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_I2C_LO;
      captured_q <= 1'b0;
    end else if (!captured_q) begin
      mode_q     <= decode_strap(miso_strap_i, strap_b_i);
      captured_q <= 1'b1;
    end
  end

  logic i2c_en, spi_en;
  logic [6:0] dev_addr;
  assign i2c_en   = captured_q & (mode_q != MODE_SPI);
  assign spi_en   = captured_q & (mode_q == MODE_SPI);
  assign dev_addr = (mode_q == MODE_I2C_HI) ? I2C_DEV_HI : I2C_DEV_LO;

  logic [2:0] sync_q;
  bus_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_sclk_i, sda_mosi_i, cs_ni}),
    .q_o    (sync_q)
  );

  logic          i2c_we, spi_we, rf_we;
  logic [AW-1:0] i2c_wa, spi_wa, i2c_ra, spi_ra, rf_wa, rf_ra;
  logic [7:0]    i2c_wd, spi_wd, rf_wd, rf_rd;

  i2c_target #(.AW(AW)) i_i2c (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (i2c_en),
    .dev_addr_i (dev_addr),
    .scl_i      (sync_q[2]),
    .sda_i      (sync_q[1]),
    .sda_oe_o   (sda_oe_o),
    .wr_en_o    (i2c_we),
    .wr_addr_o  (i2c_wa),
    .wr_data_o  (i2c_wd),
    .rd_addr_o  (i2c_ra),
    .rd_data_i  (rf_rd)
  );

  spi_target #(.AW(AW)) i_spi (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (spi_en),
    .sclk_i     (sync_q[2]),
    .cs_ni      (sync_q[0]),
    .mosi_i     (sync_q[1]),
    .miso_o     (miso_o),
    .miso_oe_o  (miso_oe_o),
    .wr_en_o    (spi_we),
    .wr_addr_o  (spi_wa),
    .wr_data_o  (spi_wd),
    .rd_addr_o  (spi_ra),
    .rd_data_i  (rf_rd)
  );

  assign rf_we = spi_en ? spi_we : i2c_we;
  assign rf_wa = spi_en ? spi_wa : i2c_wa;
  assign rf_wd = spi_en ? spi_wd : i2c_wd;
  assign rf_ra = spi_en ? spi_ra : i2c_ra;

  slave_regs #(.DEPTH(REG_DEPTH), .DATA_W(8)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (rf_we),
    .wr_addr_i (rf_wa),
    .wr_data_i (rf_wd),
    .rd_addr_i (rf_ra),
    .rd_data_o (rf_rd)
  );

  p_mode_frozen_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    captured_q |=> captured_q && $stable(mode_q));
  p_spi_no_sda_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_en |-> !sda_oe_o);
  p_i2c_no_miso_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    i2c_en |-> !miso_oe_o);

  always_comb begin
    if (!rst_ni) begin
      p_reset_quiet_r11: assert (!sda_oe_o && !miso_oe_o);
    end
  end
endmodule

// File: tb/test_strap_ctrl_slave.sv
module test_strap_ctrl_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 10;
  localparam int DEPTH      = 16;
  localparam int WD_LIMIT   = 150000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic mosi_drv = 1'b1;
  logic use_spi = 1'b0;
  logic cs_n = 1'b1;
  logic strap_a = 1'b0;
  logic strap_b = 1'b0;
  logic sda_oe, miso, miso_oe;
  logic sda_pin, miso_pin;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_mem [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_pin  = use_spi ? mosi_drv : ~(m_low | sda_oe);
  assign miso_pin = miso_oe ? miso : strap_a;

  strap_ctrl_slave #(.REG_DEPTH(DEPTH), .SYNC_STAGES(2)) i_strap_ctrl_slave (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .scl_sclk_i   (scl),
    .sda_mosi_i   (sda_pin),
    .sda_oe_o     (sda_oe),
    .cs_ni        (cs_n),
    .miso_strap_i (miso_pin),
    .strap_b_i    (strap_b),
    .miso_o       (miso),
    .miso_oe_o    (miso_oe)
  );

  task automatic tick(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] exp_rd(int a);
    return exp_mem[a % DEPTH];
  endfunction

  function automatic logic [7:0] dev_byte(bit hi, bit rd);
    return {(hi ? 7'h64 : 7'h61), rd};
  endfunction

  task automatic clear_model();
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'h00;
  endtask

  // I2C master
  task automatic i2c_start();
    m_low = 1'b0; tick(HALF);
    scl = 1'b1; tick(HALF);
    m_low = 1'b1; tick(HALF);
    scl = 1'b0;
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; tick(HALF);
    scl = 1'b1; tick(HALF);
    m_low = 1'b0; tick(HALF);
  endtask

  task automatic bit_out(bit b);
    tick(HALF/2); m_low = ~b; tick(HALF/2);
    scl = 1'b1; tick(HALF);
    scl = 1'b0;
  endtask

  task automatic bit_in(output bit b);
    tick(HALF/2); m_low = 1'b0; tick(HALF/2);
    scl = 1'b1; tick(HALF/2);
    @(negedge clk); b = sda_pin;
    tick(HALF/2);
    scl = 1'b0;
  endtask

  task automatic i2c_wr(logic [7:0] d, output bit acked);
    bit b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    acked = ~b;
  endtask

  task automatic i2c_rd(bit ack, output logic [7:0] d);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      d[i] = b;
    end
    bit_out(~ack);
  endtask

  task automatic i2c_write_burst(bit hi, int a, int n, string tag);
    bit ack;
    logic [7:0] d;
    i2c_start();
    i2c_wr(dev_byte(hi, 1'b0), ack); chk({tag, " addr ack"}, ack, 1);
    i2c_wr(8'(a), ack);             chk({tag, " hdr ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      i2c_wr(d, ack);
      chk({tag, " data ack"}, ack, 1);
      exp_mem[(a + i) % DEPTH] = d;
    end
    i2c_stop();
  endtask

  task automatic i2c_read_burst(bit hi, int a, int n, string tag);
    bit ack;
    logic [7:0] d;
    i2c_start();
    i2c_wr(dev_byte(hi, 1'b1), ack); chk({tag, " rd addr ack"}, ack, 1);
    i2c_wr(8'(a), ack);             chk({tag, " rd hdr ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      i2c_rd(i != n - 1, d);
      chk({tag, " rd data"}, d, exp_rd(a + i));
    end
    i2c_stop();
  endtask

  // SPI master, mode 3
  task automatic spi_byte(logic [7:0] t, output logic [7:0] r, output bit oe_all);
    oe_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      scl = 1'b0; mosi_drv = t[i]; tick(HALF);
      @(negedge clk); r[i] = miso_pin; oe_all &= miso_oe;
      scl = 1'b1; tick(HALF);
    end
  endtask

  task automatic spi_write(int a, int n, string tag, bit track);
    logic [7:0] r, d;
    bit oe;
    cs_n = 1'b0; tick(HALF);
    spi_byte(8'(a) & 8'h7f, r, oe);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      spi_byte(d, r, oe);
      chk({tag, " miso quiet on write"}, oe, 0);
      if (track) exp_mem[(a + i) % DEPTH] = d;
    end
    cs_n = 1'b1; tick(HALF);
    mosi_drv = 1'b1; tick(HALF);
  endtask

  task automatic spi_read(int a, int n, string tag);
    logic [7:0] r;
    bit oe;
    cs_n = 1'b0; tick(HALF);
    spi_byte(8'(a) | 8'h80, r, oe);
    for (int i = 0; i < n; i++) begin
      spi_byte(8'h00, r, oe);
      chk({tag, " miso oe"}, oe, 1);
      chk({tag, " rd data"}, r, exp_rd(a + i));
    end
    cs_n = 1'b1; tick(HALF);
    mosi_drv = 1'b1; tick(HALF);
  endtask

  task automatic do_reset(bit a, bit b);
    @(negedge clk);
    rst_ni = 1'b0; strap_a = a; strap_b = b;
    tick(5);
    @(negedge clk); rst_ni = 1'b1;
    tick(5);
    strap_a = 1'b0; strap_b = 1'b0;  // straps released after latching
    clear_model();
    tick(5);
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", WD_LIMIT, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ack, b;
    logic [7:0] d, r;
    int a, n;
    void'($urandom(32'h1357));
    clear_model();

    // reset state and bus ignored in reset
    tick(3);
    @(negedge clk);
    chk("R11 sda_oe in reset", sda_oe, 0);
    chk("R11 miso_oe in reset", miso_oe, 0);
    i2c_start();
    i2c_wr(8'hC2, ack);
    chk("R1 no ack during reset", ack, 0);
    i2c_stop();

    // ---- I2C at 0xC2 ----
    do_reset(1'b0, 1'b0);
    i2c_start();
    i2c_wr(8'hC8, ack); chk("R2 foreign addr nack", ack, 0);
    i2c_wr(8'h55, ack); chk("R2 ignored after nack", ack, 0);
    i2c_stop();

    i2c_start();
    i2c_wr(8'hC2, ack); chk("R4 addr ack", ack, 1);
    i2c_wr(8'h0E, ack); chk("R4 hdr ack", ack, 1);
    i2c_wr(8'hA1, ack); chk("R4 data ack", ack, 1);
    i2c_wr(8'hB2, ack); chk("R5 data ack", ack, 1);
    i2c_wr(8'hC3, ack); chk("R5 wrap ack", ack, 1);
    i2c_stop();
    exp_mem[14] = 8'hA1; exp_mem[15] = 8'hB2; exp_mem[0] = 8'hC3;

    // repeated start, then read across wrap, nack ends it
    i2c_start();
    i2c_wr(8'hC2, ack); chk("R3 addr before restart", ack, 1);
    i2c_wr(8'h05, ack); chk("R3 hdr before restart", ack, 1);
    i2c_start();
    i2c_wr(8'hC3, ack); chk("R3 read addr after restart", ack, 1);
    i2c_wr(8'h0E, ack); chk("R6 rd hdr ack", ack, 1);
    i2c_rd(1'b1, d); chk("R6 read first", d, exp_rd(14));
    i2c_rd(1'b1, d); chk("R6 read second", d, exp_rd(15));
    i2c_rd(1'b0, d); chk("R5 read wrapped", d, exp_rd(16));
    i2c_rd(1'b0, d); chk("R7 released after nack", d, 8'hFF);
    i2c_stop();

    for (int k = 0; k < 10; k++) begin
      a = $urandom_range(0, DEPTH - 1);
      n = $urandom_range(1, 4);
      i2c_write_burst(1'b0, a, n, "R5 rand wr");
      i2c_read_burst(1'b0, a, n, "R6 rand rd");
    end

    // SPI frame in I2C mode must do nothing
    use_spi = 1'b1;
    spi_write(0, 2, "R10 spi in i2c", 1'b0);
    use_spi = 1'b0;
    i2c_read_burst(1'b0, 0, 2, "R10 regs untouched");

    // ---- I2C at 0xC8, strap A dropped after latch ----
    do_reset(1'b1, 1'b0);
    i2c_start();
    i2c_wr(8'hC2, ack); chk("R2 low addr refused in high mode", ack, 0);
    i2c_stop();
    i2c_read_burst(1'b1, 5, 2, "R11 regs reset");
    i2c_write_burst(1'b1, 3, 3, "R1 high addr kept");
    i2c_read_burst(1'b1, 3, 3, "R1 high addr read");

    // ---- SPI ----
    do_reset(1'b0, 1'b1);
    @(negedge clk);
    chk("R9 miso_oe idle", miso_oe, 0);
    use_spi = 1'b1;
    spi_write(2, 3, "R8 spi write", 1'b1);
    spi_read(2, 3, "R9 spi read");
    spi_write(15, 2, "R8 spi wrap write", 1'b1);
    spi_read(15, 2, "R9 spi wrap read");
    @(negedge clk);
    chk("R9 miso_oe after cs high", miso_oe, 0);
    for (int k = 0; k < 8; k++) begin
      a = $urandom_range(0, DEPTH - 1);
      n = $urandom_range(1, 4);
      spi_write(a, n, "R8 rand spi wr", 1'b1);
      spi_read(a, n, "R9 rand spi rd");
    end
    use_spi = 1'b0;
    i2c_start();
    i2c_wr(8'hC2, ack); chk("R10 no i2c ack in spi mode", ack, 0);
    i2c_wr(8'h02, ack); chk("R10 no i2c hdr ack in spi mode", ack, 0);
    i2c_stop();
    use_spi = 1'b1;
    spi_read(2, 1, "R10 spi regs after i2c");
    use_spi = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule